// File: doc/BRIEF.md
# Network Port Mode Control Register

This block holds the network-side operating mode of a 10 Mb/s Ethernet controller in one 16-bit register that software reads and writes. The stored fields are the medium selection, the loopback configuration, the retry and collision-test controls, and two per-medium options. Software sets them while the controller is halted: a write lands only while the controller reports that it is stopped or suspended. Reads are always available.

The stored fields are decoded every cycle into strobes for the rest of the media logic. The port decoder yields a one-hot active medium (AUI, twisted pair or serial port) plus a flag for "no medium". An auto-select input and a serial-port enable input can override or veto the programmed choice. The loopback decoder yields one of four one-hot modes. The per-medium options reach their outputs only while their own medium is the active one. The register clears on a hard reset (the asynchronous reset pin) and on a synchronous soft reset.

Register layout (bits 15..9 read as zero): bit 0 loopback enable, bit 1 codec bypass, bit 2 force collision, bit 3 retry disable, bit 4 internal-loop select, bits 6:5 medium code, bit 7 AUI idle-high, bit 8 low receive threshold.

Top module: `netport_mode_ctrl`

## Requirements
- R1: A write (wr_en=1) updates the register at the next rising clock edge only if ctl_stopped or ctl_suspended is 1 in that cycle. A write at any other time leaves rd_data unchanged.
- R2: rd_data always shows the stored register, and bits 15..9 always read as 0 whatever was written.
- R3: rst_n low (hard) and soft_rst high (sync, priority over a write) each clear the register to 0. Asserting ctl_stopped alone changes no stored bit.
- R4: Medium code bits 6:5 select the port: 00 AUI (port_sel_oh=001), 01 twisted pair (010), 10 serial port (100, only when serial_en=1).
- R5: Code 11, and code 10 with serial_en=0, give port_sel_oh=000 and port_none=1. In every other case port_none=0 and port_sel_oh is one-hot.
- R6: With auto_sel=1, codes 00 and 01 are ignored: the port is twisted pair if auto_tp_ok=1, else AUI. Code 10 is decoded as in R4 and R5.
- R7: Loopback decode to lb_mode (one-hot): bit0=0 gives 0001 (normal) whatever bits 4 and 1 hold. Bit0=1 with bit4=0 gives 0010 (external). Bit0=1, bit4=1, bit1=0 gives 0100 (internal through the codec). Bit0=1, bit4=1, bit1=1 gives 1000 (internal, codec bypassed).
- R8: rx_low_thresh equals bit 8 only while twisted pair is the active port, else 0. aui_idle_high (1 = logic-high idle, 0 = zero-differential idle) equals bit 7 only while AUI is the active port, else 0.
- R9: no_retry always equals stored bit 3.
- R10: force_coll equals stored bit 2 only in one of the two internal loopback modes, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| ctl_stopped | input | 1 | Controller is stopped |
| ctl_suspended | input | 1 | Controller is suspended |
| auto_sel | input | 1 | Automatic medium selection enable |
| auto_tp_ok | input | 1 | Automatic selection picks twisted pair when 1 |
| serial_en | input | 1 | Serial-port medium enable |
| rd_data | output | 16 | Register read value |
| port_sel_oh | output | 3 | Active medium one-hot: bit0 AUI, bit1 twisted pair, bit2 serial |
| port_none | output | 1 | No medium selected |
| lb_mode | output | 4 | Loopback mode one-hot (see R7) |
| rx_low_thresh | output | 1 | Low receive threshold, masked to twisted pair |
| aui_idle_high | output | 1 | AUI logic-high idle, masked to AUI |
| no_retry | output | 1 | Retry disable |
| force_coll | output | 1 | Forced collision, masked to internal loopback |

## Verification
The bench builds the block with the default REG_W of 16 and a two-stage reset synchronizer. At that width the seven unused upper bits can be written all-ones and checked to read back as zero. The vector table covers every medium code against every combination of auto-select, link result and serial enable that changes the outcome. It also covers each loopback encoding, including the inert bits with loopback off. Directed tests cover write gating by stop versus suspend, and the two reset paths against a stop assertion.

// File: rtl/netport_pkg.sv
package netport_pkg;
  localparam int LOOP_B    = 0;
  localparam int EXCL_B    = 1;
  localparam int FCOL_B    = 2;
  localparam int NORETRY_B = 3;
  localparam int INTL_B    = 4;
  localparam int PSEL_LO   = 5;
  localparam int IDLE_B    = 7;
  localparam int THR_B     = 8;
  localparam int USED_BITS = 9;

  localparam int NPORT = 3;
  localparam int NLOOP = 4;

  typedef enum logic [1:0] {
    PS_AUI = 2'b00,
    PS_TP  = 2'b01,
    PS_SER = 2'b10,
    PS_RSV = 2'b11
  } psel_e;

  typedef enum int {
    LB_NORMAL = 0,
    LB_EXT    = 1,
    LB_INT_CD = 2,
    LB_INT_BY = 3
  } lb_idx_e;
endpackage

// File: rtl/netport_regfile.sv
module netport_regfile
  import netport_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ctl_stopped,
  input  logic             ctl_suspended,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << USED_BITS) - 1);

  logic             wr_ok;
  logic [REG_W-1:0] q_nxt;

  assign wr_ok = wr_en && (ctl_stopped || ctl_suspended);

  always_comb begin
    q_nxt = q;
    if (soft_rst) begin
      q_nxt = '0;
    end else if (wr_ok) begin
      q_nxt = wr_data & USED_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/netport_port_dec.sv
module netport_port_dec
  import netport_pkg::*;
(
  input  logic [1:0]       psel,
  input  logic             auto_sel,
  input  logic             auto_tp_ok,
  input  logic             serial_en,
  output logic [NPORT-1:0] port_oh,
  output logic             port_none
);
  logic [1:0] eff;

  always_comb begin
    eff = psel;
    if (auto_sel && (psel == PS_AUI || psel == PS_TP)) begin
      eff = auto_tp_ok ? PS_TP : PS_AUI;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    if (i == int'(PS_SER)) begin : g_gated
      assign port_oh[i] = (eff == 2'(i)) && serial_en;
    end else begin : g_plain
      assign port_oh[i] = (eff == 2'(i));
    end
  end

  assign port_none = ~|port_oh;
endmodule

// File: rtl/netport_loop_dec.sv
module netport_loop_dec
  import netport_pkg::*;
(
  input  logic             loop_en,
  input  logic             int_sel,
  input  logic             codec_byp,
  output logic [NLOOP-1:0] lb_mode
);
  always_comb begin
    lb_mode = '0;
    if (!loop_en) begin
      lb_mode[LB_NORMAL] = 1'b1;
    end else if (!int_sel) begin
      lb_mode[LB_EXT] = 1'b1;
    end else if (!codec_byp) begin
      lb_mode[LB_INT_CD] = 1'b1;
    end else begin
      lb_mode[LB_INT_BY] = 1'b1;
    end
  end
endmodule

// File: rtl/netport_mode_ctrl.sv
module netport_mode_ctrl
  import netport_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ctl_stopped,
  input  logic             ctl_suspended,
  input  logic             auto_sel,
  input  logic             auto_tp_ok,
  input  logic             serial_en,
  output logic [REG_W-1:0] rd_data,
  output logic [2:0]       port_sel_oh,
  output logic             port_none,
  output logic [3:0]       lb_mode,
  output logic             rx_low_thresh,
  output logic             aui_idle_high,
  output logic             no_retry,
  output logic             force_coll
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [REG_W-1:0]       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  netport_regfile #(.REG_W(REG_W)) u_reg (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .soft_rst      (soft_rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .ctl_stopped   (ctl_stopped),
    .ctl_suspended (ctl_suspended),
    .q             (mode_q)
  );

  netport_port_dec u_port (
    .psel       (mode_q[PSEL_LO+1:PSEL_LO]),
    .auto_sel   (auto_sel),
    .auto_tp_ok (auto_tp_ok),
    .serial_en  (serial_en),
    .port_oh    (port_sel_oh),
    .port_none  (port_none)
  );

  netport_loop_dec u_loop (
    .loop_en   (mode_q[LOOP_B]),
    .int_sel   (mode_q[INTL_B]),
    .codec_byp (mode_q[EXCL_B]),
    .lb_mode   (lb_mode)
  );

  assign rd_data       = mode_q;
  assign rx_low_thresh = mode_q[THR_B]  & port_sel_oh[int'(PS_TP)];
  assign aui_idle_high = mode_q[IDLE_B] & port_sel_oh[int'(PS_AUI)];
  assign no_retry      = mode_q[NORETRY_B];
  assign force_coll    = mode_q[FCOL_B] & (lb_mode[LB_INT_CD] | lb_mode[LB_INT_BY]);
endmodule

// File: rtl/netport_mode_chk.sv
module netport_mode_chk
  import netport_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             ctl_stopped,
  input logic             ctl_suspended,
  input logic [REG_W-1:0] rd_data,
  input logic [2:0]       port_sel_oh,
  input logic             port_none,
  input logic [3:0]       lb_mode,
  input logic             rx_low_thresh,
  input logic             aui_idle_high,
  input logic             force_coll
);
  localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << USED_BITS) - 1);

  p_wr_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_stopped && !ctl_suspended && !soft_rst) |=> $stable(rd_data));

  p_wr_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ctl_stopped || ctl_suspended) && !soft_rst)
      |=> (rd_data == ($past(wr_data) & USED_MASK)));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED_MASK) == '0);

  p_soft_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == '0));

  p_port_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel_oh) && (port_none == (port_sel_oh == 3'b000)));

  p_lb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lb_mode) == 1);

  p_thresh_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_low_thresh |-> port_sel_oh[1]);

  p_idle_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aui_idle_high |-> port_sel_oh[0]);

  p_fcoll_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_coll |-> (lb_mode[2] || lb_mode[3]));
endmodule

bind netport_mode_ctrl netport_mode_chk #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .soft_rst      (soft_rst),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .ctl_stopped   (ctl_stopped),
  .ctl_suspended (ctl_suspended),
  .rd_data       (rd_data),
  .port_sel_oh   (port_sel_oh),
  .port_none     (port_none),
  .lb_mode       (lb_mode),
  .rx_low_thresh (rx_low_thresh),
  .aui_idle_high (aui_idle_high),
  .force_coll    (force_coll)
);

// File: tb/netport_mode_ctrl_test.sv
module netport_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  // Vector: {reg[8:0], auto_sel, serial_en, auto_tp_ok,
  //          {none,ser,tp,aui}, lb_mode[3:0], thresh, idle, fcoll}
  localparam logic [22:0] VEC [NV] = '{
    {9'h000, 3'b000, 4'b0001, 4'b0001, 3'b000},  // AUI, normal
    {9'h080, 3'b000, 4'b0001, 4'b0001, 3'b010},  // idle-high on AUI
    {9'h100, 3'b000, 4'b0001, 4'b0001, 3'b000},  // threshold masked on AUI
    {9'h120, 3'b000, 4'b0010, 4'b0001, 3'b100},  // threshold on TP
    {9'h0A0, 3'b000, 4'b0010, 4'b0001, 3'b000},  // idle masked on TP
    {9'h040, 3'b010, 4'b0100, 4'b0001, 3'b000},  // serial enabled
    {9'h040, 3'b000, 4'b1000, 4'b0001, 3'b000},  // serial not enabled
    {9'h060, 3'b010, 4'b1000, 4'b0001, 3'b000},  // reserved code
    {9'h000, 3'b101, 4'b0010, 4'b0001, 3'b000},  // auto overrides AUI -> TP
    {9'h020, 3'b100, 4'b0001, 4'b0001, 3'b000},  // auto overrides TP -> AUI
    {9'h040, 3'b111, 4'b0100, 4'b0001, 3'b000},  // auto leaves serial
    {9'h040, 3'b101, 4'b1000, 4'b0001, 3'b000},  // auto, serial disabled
    {9'h100, 3'b101, 4'b0010, 4'b0001, 3'b100},  // threshold follows auto TP
    {9'h001, 3'b000, 4'b0001, 4'b0010, 3'b000},  // external loopback
    {9'h003, 3'b000, 4'b0001, 4'b0010, 3'b000},  // external, bypass inert
    {9'h011, 3'b000, 4'b0001, 4'b0100, 3'b000},  // internal via codec
    {9'h013, 3'b000, 4'b0001, 4'b1000, 3'b000},  // internal bypass
    {9'h012, 3'b000, 4'b0001, 4'b0001, 3'b000},  // loop off, others inert
    {9'h015, 3'b000, 4'b0001, 4'b0100, 3'b001},  // forced collision internal
    {9'h005, 3'b000, 4'b0001, 4'b0010, 3'b000}   // forced collision masked
  };

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, wr_en;
  logic [15:0] wr_data;
  logic        ctl_stopped, ctl_suspended, auto_sel, auto_tp_ok, serial_en;
  logic [15:0] rd_data;
  logic [2:0]  port_sel_oh;
  logic        port_none;
  logic [3:0]  lb_mode;
  logic        rx_low_thresh, aui_idle_high, no_retry, force_coll;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  netport_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .ctl_stopped(ctl_stopped), .ctl_suspended(ctl_suspended),
    .auto_sel(auto_sel), .auto_tp_ok(auto_tp_ok), .serial_en(serial_en),
    .rd_data(rd_data), .port_sel_oh(port_sel_oh), .port_none(port_none),
    .lb_mode(lb_mode), .rx_low_thresh(rx_low_thresh),
    .aui_idle_high(aui_idle_high), .no_retry(no_retry), .force_coll(force_coll)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
    ctl_stopped = 1'b0; ctl_suspended = 1'b0;
    auto_sel = 1'b0; auto_tp_ok = 1'b0; serial_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R3: reset state
    check("R3 reset rd_data", 32'(rd_data), 32'h0);
    check("R4 reset port", 32'({port_none, port_sel_oh}), 32'b0001);
    check("R7 reset lb", 32'(lb_mode), 32'b0001);

    // R1: write ignored while running
    write_reg(16'h0013);
    check("R1 write while running ignored", 32'(rd_data), 32'h0);
    check("R1 loopback unchanged", 32'(lb_mode), 32'b0001);

    // R1: write accepted while suspended only
    ctl_suspended = 1'b1;
    write_reg(16'h0013);
    check("R1 write while suspended", 32'(rd_data), 32'h0013);
    ctl_suspended = 1'b0;

    // R2: unused bits read as zero, R9 retry disable
    ctl_stopped = 1'b1;
    write_reg(16'hFFFF);
    check("R2 unused bits zero", 32'(rd_data), 32'h01FF);
    check("R9 no_retry set", 32'(no_retry), 32'h1);
    write_reg(16'hFFF7);
    check("R9 no_retry clear", 32'(no_retry), 32'h0);

    // R4..R10 table
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      auto_sel = v[13]; serial_en = v[12]; auto_tp_ok = v[11];
      write_reg({7'b0, v[22:14]});
      check($sformatf("R4 R5 R6 port vec%0d", i), 32'({port_none, port_sel_oh}), 32'(v[10:7]));
      check($sformatf("R7 lb vec%0d", i), 32'(lb_mode), 32'(v[6:3]));
      check($sformatf("R8 thresh vec%0d", i), 32'(rx_low_thresh), 32'(v[2]));
      check($sformatf("R8 idle vec%0d", i), 32'(aui_idle_high), 32'(v[1]));
      check($sformatf("R10 fcoll vec%0d", i), 32'(force_coll), 32'(v[0]));
    end
    auto_sel = 1'b0; serial_en = 1'b0; auto_tp_ok = 1'b0;

    // R3: stop toggling alone keeps contents
    write_reg(16'h01A5);
    ctl_stopped = 1'b0;
    @(negedge clk);
    ctl_stopped = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R3 stop keeps register", 32'(rd_data), 32'h01A5);

    // R3: soft reset beats a simultaneous write
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; wr_data = 16'h00FF;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    #1;
    check("R3 soft reset clears", 32'(rd_data), 32'h0);

    // R3: hard reset clears
    write_reg(16'h0155);
    check("R1 write while stopped", 32'(rd_data), 32'h0155);
    rst_n = 1'b0;
    #1;
    check("R3 hard reset clears", 32'(rd_data), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule